// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects interrupt requests from many hardware sources and presents at most one of them to the processor at a time. The sources are organised into groups of four. Each group has one control word that holds the four latched request flags, a matching set of enable flags and a single 3-bit priority level. That level applies to every source in the group. A source is pending while both its request flag and its enable flag are set.

On every cycle the controller looks at all groups that have a pending source and whose level is strictly below the processor's current mask level. It picks the group with the numerically smallest level, which is the highest priority. When levels are equal, the lowest group number wins. The processor's global interrupt-enable flag gates the result. The controller registers an interrupt request, the accepted group number and that group's level.

Software reaches the control words over a simple single-cycle register bus, one 32-bit word per group. Requests stay latched until software clears them by writing a one to the flag.

Top module: `gpic_top`

## Requirements
- R1: After reset every request, enable and level field is 0, and `irq_o`, `irq_grp_o` and `irq_lvl_o` are 0.
- R2: The word of group g sits at byte address 4*g. In that word the request flags are bits 3..0, the enables are bits 11..8, the level is bits 14..12, and all other bits read as 0. A write stores the enable and level fields as written.
- R3: A source is pending when its request and enable flags are both 1. Setting the enable while the request is already 1 raises `irq_o`, provided the level and gates allow it.
- R4: A one-cycle pulse on `src_set` bit 4*g+b sets request flag b of group g, and the flag stays set after the pulse ends.
- R5: Writing 1 to a request flag clears it, and writing 0 leaves it unchanged. When a source pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R6: A group can be accepted only when its level is strictly less than `cpu_mask`.
- R7: Among the eligible groups, the one with the smallest level value is accepted.
- R8: When eligible groups share the smallest level, the one with the lowest group number is accepted.
- R9: While `cpu_gie` is 0, `irq_o` is 0 and the latched requests are kept.
- R10: The outputs are registered. They reflect register and input state one clock later, and `irq_grp_o` and `irq_lvl_o` are 0 whenever `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | 32 | Request pulses, bit 4*g+b for source b of group g |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte address; group index in bits 4..2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| cpu_gie | input | 1 | Global interrupt enable from the processor |
| cpu_mask | input | 3 | Processor mask level |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_grp_o | output | 3 | Accepted group number |
| irq_lvl_o | output | 3 | Accepted group level |

## Verification
Some properties are checked on every cycle. The request line stays low in the cycle after the global enable is low. Any accepted level is strictly below the mask seen a cycle earlier. The accepted group really had a pending source. The group and level outputs are zero when idle. Source pulses latch their flags, and write-one clears without a pulse take effect. Other behaviours only show up in the bench's scenarios: the exact winner among competing groups, tie-breaking by group number, the register bit layout, and the one-cycle output latency. The bench sweeps every group against every level and mask pair, and it runs a series of multi-group contention patterns with deliberate ties.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
    localparam int SRC_PER_GRP = 4;
    localparam int LVL_W       = 3;
    localparam int REQ_LSB     = 0;
    localparam int EN_LSB      = 8;
    localparam int LVL_LSB     = 12;

    typedef logic [LVL_W-1:0]       lvl_t;
    typedef logic [SRC_PER_GRP-1:0] src_vec_t;

    typedef struct packed {
        lvl_t     lvl;
        src_vec_t en;
        src_vec_t req;
    } grp_cfg_t;
endpackage

// File: rtl/gpic_group_reg.sv
module gpic_group_reg
    import gpic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  src_vec_t    src_set,
    output grp_cfg_t    cfg_o,
    output logic        pend_o
);
    grp_cfg_t cfg_q;
    src_vec_t clr_mask;

    always_comb begin
        clr_mask = wr_en ? wdata[REQ_LSB +: SRC_PER_GRP] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (wr_en) begin
                cfg_q.lvl <= wdata[LVL_LSB +: LVL_W];
                cfg_q.en  <= wdata[EN_LSB +: SRC_PER_GRP];
            end
            cfg_q.req <= (cfg_q.req & ~clr_mask) | src_set;
        end
    end

    assign cfg_o  = cfg_q;
    assign pend_o = |(cfg_q.req & cfg_q.en);

    // R4: a pulse leaves its flag set
    a_r4_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((cfg_q.req & $past(src_set)) == $past(src_set)));

    // R5: a clear without a competing pulse empties the flag
    a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask & ~src_set) != '0 |=> ((cfg_q.req & $past(clr_mask & ~src_set)) == '0));
endmodule

// File: rtl/gpic_arbiter.sv
module gpic_arbiter
    import gpic_pkg::*;
#(
    parameter int NUM_GRP = 8,
    localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic [NUM_GRP-1:0][LVL_W-1:0] lvls,
    input  logic [NUM_GRP-1:0]            elig,
    output logic                          found_o,
    output logic [GW-1:0]                 win_grp_o,
    output lvl_t                          win_lvl_o
);
    always_comb begin
        found_o   = 1'b0;
        win_grp_o = '0;
        win_lvl_o = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int g = 0; g < NUM_GRP; g++) begin
            if (elig[g] && (!found_o || (lvls[g] < win_lvl_o))) begin
                found_o   = 1'b1;
                win_grp_o = GW'(g);
                win_lvl_o = lvls[g];
            end
        end
    end
endmodule

// File: rtl/gpic_top.sv
module gpic_top
    import gpic_pkg::*;
#(
    parameter int NUM_GRP = 8,
    localparam int GW = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int AW = GW + 2,
    localparam int NSRC = NUM_GRP * SRC_PER_GRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic            cpu_gie,
    input  logic [2:0]      cpu_mask,
    output logic            irq_o,
    output logic [GW-1:0]   irq_grp_o,
    output logic [2:0]      irq_lvl_o
);
    logic [GW-1:0]                 rsel;
    logic                          rsel_ok;
    grp_cfg_t                      cfg   [NUM_GRP];
    logic [NUM_GRP-1:0]            pend;
    logic [NUM_GRP-1:0]            elig;
    logic [NUM_GRP-1:0][LVL_W-1:0] lvls;
    logic                          found;
    logic [GW-1:0]                 win_grp;
    lvl_t                          win_lvl;
    logic                          irq_q;
    logic [GW-1:0]                 grp_q;
    lvl_t                          lvl_q;

    assign rsel    = bus_addr[AW-1:2];
    assign rsel_ok = (int'(rsel) < NUM_GRP);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        gpic_group_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_sel && bus_wr && rsel_ok && (int'(rsel) == g)),
            .wdata   (bus_wdata),
            .src_set (src_set[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .cfg_o   (cfg[g]),
            .pend_o  (pend[g])
        );
        assign lvls[g] = cfg[g].lvl;
        assign elig[g] = pend[g] && (cfg[g].lvl < cpu_mask);
    end

    gpic_arbiter #(.NUM_GRP(NUM_GRP)) u_arb (
        .lvls      (lvls),
        .elig      (elig),
        .found_o   (found),
        .win_grp_o (win_grp),
        .win_lvl_o (win_lvl)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && rsel_ok) begin
            bus_rdata[REQ_LSB +: SRC_PER_GRP] = cfg[rsel].req;
            bus_rdata[EN_LSB  +: SRC_PER_GRP] = cfg[rsel].en;
            bus_rdata[LVL_LSB +: LVL_W]       = cfg[rsel].lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            grp_q <= '0;
            lvl_q <= '0;
        end else begin
            irq_q <= cpu_gie && found;
            grp_q <= (cpu_gie && found) ? win_grp : '0;
            lvl_q <= (cpu_gie && found) ? win_lvl : '0;
        end
    end

    assign irq_o     = irq_q;
    assign irq_grp_o = grp_q;
    assign irq_lvl_o = lvl_q;

    a_r9_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_gie |=> !irq_q);

    a_r6_mask_strict: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (lvl_q < $past(cpu_mask)));

    a_r3_pending_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ((($past(pend) >> grp_q) & NUM_GRP'(1)) != '0));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_q |-> (grp_q == '0 && lvl_q == '0));
endmodule

// File: tb/gpic_top_tb_top.sv
module gpic_top_tb_top;
    localparam int NG = 8;
    localparam int GW = 3;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*4-1:0] src_set = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          cpu_gie = 1'b0;
    logic [2:0]    cpu_mask = '0;
    logic          irq_o;
    logic [GW-1:0] irq_grp_o;
    logic [2:0]    irq_lvl_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpic_top #(.NUM_GRP(NG)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_set(src_set),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_gie(cpu_gie), .cpu_mask(cpu_mask),
        .irq_o(irq_o), .irq_grp_o(irq_grp_o), .irq_lvl_o(irq_lvl_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int g, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(g * 4); bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int g, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(g * 4);
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [NG*4-1:0] v);
        src_set = v;
        tick();
        src_set = '0;
    endtask

    function automatic logic [31:0] outv();
        return {25'b0, irq_o, irq_grp_o, irq_lvl_o};
    endfunction

    function automatic logic [31:0] expv(input bit irq, input int g, input int l);
        return irq ? {25'b0, 1'b1, GW'(g), 3'(l)} : 32'h0;
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int g = 0; g < NG; g++) begin
            rd(g, d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset outputs", outv(), 32'h0);

        // R2: layout, unused bits zero
        wr(2, 32'hFFFF_FFFF);
        rd(2, d);
        check("R2 layout readback", d, 32'h0000_7F00);
        wr(2, 32'h0);
        rd(2, d);
        check("R2 fields rewritten", d, 32'h0);

        // R4 and R5: latching and write-one-to-clear
        pulse(32'h1 << 13);
        tick();
        rd(3, d);
        check("R4 pulse latched", d, 32'h2);
        wr(3, 32'h0);
        rd(3, d);
        check("R5 write zero keeps flag", d, 32'h2);
        wr(3, 32'h2);
        rd(3, d);
        check("R5 write one clears flag", d, 32'h0);
        src_set = 32'h1 << 13;
        wr(3, 32'h2);
        src_set = '0;
        rd(3, d);
        check("R5 set beats clear", d, 32'h2);
        wr(3, 32'h2);

        // R3 and R10: enable after request, one-cycle latency
        cpu_gie = 1'b1; cpu_mask = 3'd7;
        pulse(32'h1 << 20);
        wr(5, (32'd3 << 12) | (32'h1 << 8));
        check("R10 no output before next edge", outv(), 32'h0);
        tick();
        check("R3 enable on latched request", outv(), expv(1, 5, 3));

        // R9: global enable gate keeps requests latched
        cpu_gie = 1'b0;
        tick(); tick();
        check("R9 gie low blocks irq", outv(), 32'h0);
        rd(5, d);
        check("R9 request still latched", d, 32'h0000_3101);
        cpu_gie = 1'b1;
        tick();
        check("R9 irq after gie returns", outv(), expv(1, 5, 3));
        wr(5, 32'hF);
        tick();

        // R6: every group against every level and mask
        for (int g = 0; g < NG; g++) begin
            for (int l = 0; l < 8; l++) begin
                for (int m = 0; m < 8; m++) begin
                    pulse(32'h1 << (g * 4 + (l % 4)));
                    wr(g, (32'(l) << 12) | (32'h1 << (8 + (l % 4))));
                    cpu_mask = 3'(m);
                    tick();
                    check($sformatf("R6 g=%0d lvl=%0d mask=%0d", g, l, m),
                          outv(), expv(l < m, g, l));
                    wr(g, 32'hF);
                end
            end
        end
        tick();

        // R7 and R8: contention patterns with ties
        for (int p = 0; p < 24; p++) begin
            int lv [NG];
            int en [NG];
            int m;
            bit f;
            int bg;
            int bl;
            pulse('1);
            m = (p % 3 == 0) ? 5 : 7;
            for (int g = 0; g < NG; g++) begin
                lv[g] = (p < 12) ? ((g * 3 + p * 5) % 8) : ((g + p) % 3 + 1);
                en[g] = ((g + p) % 3 == 0) ? 0 : ((g * 7 + p) % 15 + 1);
                wr(g, (32'(lv[g]) << 12) | (32'(en[g]) << 8));
            end
            cpu_mask = 3'(m);
            tick();
            f = 1'b0; bg = 0; bl = 0;
            for (int g = 0; g < NG; g++) begin
                if (en[g] != 0 && lv[g] < m && (!f || lv[g] < bl)) begin
                    f = 1'b1; bg = g; bl = lv[g];
                end
            end
            check($sformatf("R7 R8 pattern %0d", p), outv(), expv(f, bg, bl));
            for (int g = 0; g < NG; g++) wr(g, 32'hF);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule